// File: doc/BRIEF.md
# Pixel Lookup Table

This block remaps every displayed pixel through a host-loaded table. The table has one entry for each possible pixel value, and each entry holds an output intensity of the same width. An incoming pixel stream with a valid strobe is translated entry by entry. The mapped pixel leaves the block one clock later, and the valid strobe is delayed to match.

The host fills the table through two write-only ports. A write to the index port latches which entry to address. A later write to the entry port stores a value into the latched entry. Entry writes take effect only while the load-permit control is high and the stored-image control is low. A blanking control forces accepted pixels to black without touching the table.

Table contents are undefined after reset. The host is expected to load an identity map at start-up, which gives a transparent display.

Top module: `pix_lut`

## Requirements
- R1: The table has 2^PIX_W entries of PIX_W bits (256 x 8 by default). A pixel p accepted on a clock edge with `pix_vld` high appears as table[p] on `pix_out` after that edge.
- R2: An `ent_wr` pulse stores `ent_val` into the entry selected by the latched index, when writes are permitted.
- R3: An `idx_wr` pulse latches `idx_val`. The index never auto-increments, so repeated entry writes without a new index write all land in the same entry.
- R4: An entry write while `cfg_load_en` is 0 is ignored and leaves the table unchanged.
- R5: An entry write while `cfg_show_stored` is 1 is ignored, even when `cfg_load_en` is 1.
- R6: A pixel accepted while `cfg_blank` is 1 produces 0 on `pix_out`. Blanking does not alter the table.
- R7: `out_vld` is `pix_vld` delayed by one clock. While `pix_vld` is low, `pix_out` holds its last value.
- R8: When an index write and an entry write fall in the same cycle, the data goes to the previously latched index. The new index applies to the following entry writes.
- R9: When a pixel lookup and an entry write hit the same entry in the same cycle, the lookup returns the content from before the write.
- R10: During and after reset, `out_vld` and `pix_out` are 0 and the latched index is 0.
- R11: With an identity table loaded, `pix_out` equals the accepted pixel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_en | input | 1 | Permits table writes when high |
| cfg_show_stored | input | 1 | Stored-image display; blocks table writes when high |
| cfg_blank | input | 1 | Forces accepted pixels to black |
| idx_wr | input | 1 | Index port write strobe |
| idx_val | input | PIX_W | Index port data |
| ent_wr | input | 1 | Entry port write strobe |
| ent_val | input | PIX_W | Entry port data |
| pix_vld | input | 1 | Input pixel valid |
| pix_in | input | PIX_W | Input pixel value |
| out_vld | output | 1 | Mapped pixel valid |
| pix_out | output | PIX_W | Mapped pixel value |

## Verification
Two pairs of functions can coincide in one cycle. An index write can meet an entry write, and a host write can meet a pixel lookup of the same entry. The bench provokes the first by pulsing both strobes on the same edge, then reads back the old and new index entries through the pixel path. It provokes the second by driving a pixel equal to the latched index on the same edge as the entry write. It judges that the first output carries the old value and that a later lookup carries the new one.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;

  localparam int unsigned LUT_PIX_W = 8;

  // Table writes are honoured only with load permitted and stored view off.
  function automatic logic lut_wr_permit(input logic load_en, input logic show_stored);
    return load_en & ~show_stored;
  endfunction

endpackage

// File: rtl/pix_lut_host.sv
module pix_lut_host #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          show_stored,
  input  logic          idx_wr,
  input  logic [AW-1:0] idx_val,
  input  logic          ent_wr,
  input  logic [DW-1:0] ent_val,
  output logic          we,
  output logic [AW-1:0] wa,
  output logic [DW-1:0] wd
);

  logic [AW-1:0] idx_q;
  logic [AW-1:0] idx_d;

  // Next-state logic for the latched index (no auto-increment).
  always_comb begin
    idx_d = idx_q;
    if (idx_wr) idx_d = idx_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // The entry write uses the index latched before this edge.
  always_comb begin
    we = ent_wr & pix_lut_pkg::lut_wr_permit(load_en, show_stored);
    wa = idx_q;
    wd = ent_val;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q)); // R3

  AST_IDX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(idx_val))); // R8

endmodule

// File: rtl/pix_lut_mem.sv
module pix_lut_mem #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] tbl;

  // One enabled register per entry; contents are not reset.
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (wa == AW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) tbl[g] <= wd;
    end
  end

  // Read returns the content held before any write on this edge.
  assign rd = tbl[ra];

  AST_TBL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (tbl === $past(tbl))); // R4

  AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tbl[$past(wa)] === $past(wd))); // R2

endmodule

// File: rtl/pix_lut_out.sv
module pix_lut_out #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld,
  input  logic          blank,
  input  logic [DW-1:0] lut_rd,
  output logic          out_vld,
  output logic [DW-1:0] pix_out
);

  logic [DW-1:0] pix_d;

  always_comb begin
    pix_d = lut_rd;
    if (blank) pix_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= pix_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pix_out <= '0;
    else if (pix_vld) pix_out <= pix_d;
  end

endmodule

// File: rtl/pix_lut.sv
module pix_lut #(
  parameter int unsigned PIX_W = pix_lut_pkg::LUT_PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_en,
  input  logic             cfg_show_stored,
  input  logic             cfg_blank,
  input  logic             idx_wr,
  input  logic [PIX_W-1:0] idx_val,
  input  logic             ent_wr,
  input  logic [PIX_W-1:0] ent_val,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  output logic             out_vld,
  output logic [PIX_W-1:0] pix_out
);

  logic             we;
  logic [PIX_W-1:0] wa;
  logic [PIX_W-1:0] wd;
  logic [PIX_W-1:0] lut_rd;

  pix_lut_host #(.AW(PIX_W), .DW(PIX_W)) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (cfg_load_en),
    .show_stored (cfg_show_stored),
    .idx_wr      (idx_wr),
    .idx_val     (idx_val),
    .ent_wr      (ent_wr),
    .ent_val     (ent_val),
    .we          (we),
    .wa          (wa),
    .wd          (wd)
  );

  pix_lut_mem #(.AW(PIX_W), .DW(PIX_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .wa    (wa),
    .wd    (wd),
    .ra    (pix_in),
    .rd    (lut_rd)
  );

  pix_lut_out #(.DW(PIX_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_vld (pix_vld),
    .blank   (cfg_blank),
    .lut_rd  (lut_rd),
    .out_vld (out_vld),
    .pix_out (pix_out)
  );

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && cfg_blank) |=> (pix_out == '0)); // R6

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> out_vld); // R7

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> !out_vld); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> $stable(pix_out)); // R7

endmodule

// File: tb/pix_lut_bench.sv
module pix_lut_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_load_en, cfg_show_stored, cfg_blank;
  logic         idx_wr, ent_wr, pix_vld;
  logic [W-1:0] idx_val, ent_val, pix_in;
  logic         out_vld;
  logic [W-1:0] pix_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // {pixel, mapped value}
  localparam logic [15:0] VEC [8] = '{
    16'h01_3C, 16'h02_C3, 16'h7F_00, 16'h80_FF,
    16'hC8_12, 16'hFE_81, 16'hFF_7E, 16'h03_A5
  };

  always #4 clk = ~clk;

  pix_lut u_pix_lut (
    .clk(clk), .rst_n(rst_n),
    .cfg_load_en(cfg_load_en), .cfg_show_stored(cfg_show_stored), .cfg_blank(cfg_blank),
    .idx_wr(idx_wr), .idx_val(idx_val), .ent_wr(ent_wr), .ent_val(ent_val),
    .pix_vld(pix_vld), .pix_in(pix_in), .out_vld(out_vld), .pix_out(pix_out)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic put_idx(input logic [W-1:0] v);
    idx_wr = 1'b1; idx_val = v;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic put_ent(input logic [W-1:0] v);
    ent_wr = 1'b1; ent_val = v;
    @(negedge clk);
    ent_wr = 1'b0;
  endtask

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] v);
    put_idx(a);
    put_ent(v);
  endtask

  task automatic look(input string req, input logic [W-1:0] p, input logic [W-1:0] exp);
    pix_vld = 1'b1; pix_in = p;
    @(negedge clk);
    pix_vld = 1'b0;
    chk(req, pix_out, exp);
    chk(req, {7'd0, out_vld}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_load_en = 1'b0; cfg_show_stored = 1'b0; cfg_blank = 1'b0;
    idx_wr = 1'b0; ent_wr = 1'b0; pix_vld = 1'b0;
    idx_val = '0; ent_val = '0; pix_in = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {7'd0, out_vld}, 8'd0);
    chk("R10", pix_out, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_load_en = 1'b1;
    // R10: latched index is 0 after reset
    put_ent(8'h5A);
    look("R10", 8'd0, 8'h5A);

    // R11: identity table
    for (int i = 0; i < 256; i++) load(W'(i), W'(i));
    for (int i = 0; i < 256; i++) look("R11", W'(i), W'(i));

    // R1/R2: vector table
    for (int i = 0; i < 8; i++) load(VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) look("R1", VEC[i][15:8], VEC[i][7:0]);

    // R3: no auto-increment
    load(8'd40, 8'h11);
    put_ent(8'h22);
    look("R3", 8'd40, 8'h22);
    look("R3", 8'd41, 8'd41);

    // R4: load not permitted
    cfg_load_en = 1'b0;
    load(8'd50, 8'hAA);
    look("R4", 8'd50, 8'd50);

    // R5: stored view blocks writes
    cfg_load_en = 1'b1; cfg_show_stored = 1'b1;
    load(8'd51, 8'hBB);
    look("R5", 8'd51, 8'd51);
    cfg_show_stored = 1'b0;

    // R6: blanking
    cfg_blank = 1'b1;
    look("R6", 8'd100, 8'd0);
    cfg_blank = 1'b0;
    look("R6", 8'd100, 8'd100);

    // R7: idle input holds output
    look("R7", 8'd7, 8'd7);
    pix_in = 8'd9;
    repeat (3) @(negedge clk);
    chk("R7", {7'd0, out_vld}, 8'd0);
    chk("R7", pix_out, 8'd7);

    // R8: index and entry write together
    put_idx(8'd60);
    idx_wr = 1'b1; idx_val = 8'd61; ent_wr = 1'b1; ent_val = 8'h66;
    @(negedge clk);
    idx_wr = 1'b0; ent_wr = 1'b0;
    look("R8", 8'd60, 8'h66);
    look("R8", 8'd61, 8'd61);
    put_ent(8'h77);
    look("R8", 8'd61, 8'h77);

    // R9: lookup and write of the same entry together
    put_idx(8'd70);
    ent_wr = 1'b1; ent_val = 8'h99; pix_vld = 1'b1; pix_in = 8'd70;
    @(negedge clk);
    ent_wr = 1'b0; pix_vld = 1'b0;
    chk("R9", pix_out, 8'd70);
    look("R9", 8'd70, 8'h99);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule